// File: doc/BRIEF.md
# Framed Send-Path Transmitter With Bus Request

This block is the outgoing half of a slave node's network interface. The local resource hands it a stream of payload bytes, the last one flagged. The block packs those bytes into a complete frame in an internal send buffer while it runs a 32-bit CRC over the data field. When the payload ends, it writes the header in front of the data and the CRC behind it.

Only when the whole frame sits in the buffer does the block raise its request to the arbiter of the shared return bus. After the grant arrives it plays the buffer out, one byte per cycle with no gaps. It marks the first and last bytes with strobes, then drops the request and pulses a completion flag. Because the frame is complete before the request goes out, a granted transfer never waits on the local resource.

The node can also send a short control frame that asks the far end to send again. It takes the addresses from the header inputs and carries no data. A payload longer than the buffer allows is dropped whole and reported.

Top module: `ftx_framer`

## Requirements
- R1: The frame leaves in this byte order: destination (2 bytes), source (2 bytes), type (1 byte), length (2 bytes), data bytes, CRC (4 bytes). Every multi-byte field goes most significant byte first. Destination, source and type are sampled from the header inputs when the first payload byte is accepted.
- R2: The length field equals the number of payload bytes accepted, counting the byte that carries the last flag. A frame may carry 1 to MAX_PAYLOAD (default 2048) data bytes, and exactly MAX_PAYLOAD is legal.
- R3: The CRC field is the reflected CRC-32 (polynomial 0x04C11DB7, bit-reversed form 0xEDB88320) over the data bytes only. The register is preset to all ones and the result is inverted. For the ASCII data "123456789" the field is 0xCBF43926.
- R4: bus_req stays low while payload is being taken in and while the header and CRC are written. It rises only after the complete frame is in the buffer.
- R5: tx_valid is never high unless bus_req is high. The first byte appears in the cycle after bus_grant is seen high while requesting. From then on tx_valid stays high every cycle until the last byte.
- R6: tx_sof is high only with the first byte of the frame, and tx_eof is high only with the last CRC byte.
- R7: In the cycle after the tx_eof byte, bus_req is low and frame_done is high for exactly one cycle.
- R8: in_ready is low from the moment a frame is complete until its frame_done cycle has passed, so no payload is taken while waiting for the grant or while sending.
- R9: If a payload exceeds MAX_PAYLOAD bytes, ovf_err pulses for one cycle. The rest of the payload, up to and including the byte with the last flag, is accepted and discarded, and no request is made. The next payload forms a normal frame.
- R10: A one-cycle resend_req while idle produces an 11-byte frame with type 0xE0, length 0 and CRC field 0x00000000. Its addresses are taken from hdr_dst and hdr_src.
- R11: After reset, bus_req, tx_valid, tx_sof, tx_eof, frame_done and ovf_err are low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Payload byte present |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Marks the final payload byte |
| in_ready | output | 1 | Block accepts a payload byte this cycle |
| hdr_dst | input | 16 | Destination address for the frame |
| hdr_src | input | 16 | Source address for the frame |
| hdr_type | input | 8 | Type code for a data frame |
| resend_req | input | 1 | Ask to send a resend-request frame |
| bus_grant | input | 1 | Grant from the return-bus arbiter |
| bus_req | output | 1 | Request for the return bus |
| tx_valid | output | 1 | Byte on tx_data is valid |
| tx_data | output | 8 | Outgoing frame byte |
| tx_sof | output | 1 | First byte of a frame |
| tx_eof | output | 1 | Last byte of a frame |
| frame_done | output | 1 | One-cycle pulse after a frame is sent |
| ovf_err | output | 1 | One-cycle pulse when a payload is too long |

## Verification
A wrong buffer write address or a stale counter shows up as a misplaced header byte, a wrong length or a frame of the wrong size. The bench sees this on the first frame it reassembles. A bad CRC update shows in the last four bytes of every frame with data, and the standard check string exposes it within one frame. Faults in the sequencing show within one or two cycles of the event at fault, because the bench watches the request, strobe and completion timing at every cycle edge: a request raised too early, a gap in the stream, a misplaced strobe or a missing completion pulse. The overflow path is exposed when a request appears for a dropped payload, or when the next frame comes out corrupted.

// File: rtl/ftx_pkg.sv
package ftx_pkg;

    localparam int HDR_BYTES = 7;
    localparam int CRC_BYTES = 4;
    localparam int SEAL_STEPS = HDR_BYTES + CRC_BYTES;
    localparam logic [7:0] RESEND_TYPE = 8'hE0;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_DROP,
        ST_SEAL,
        ST_WAIT,
        ST_SEND,
        ST_DONE
    } ftx_state_e;

    typedef struct packed {
        logic [15:0] dst;
        logic [15:0] src;
        logic [7:0]  ftype;
    } ftx_hdr_t;

    function automatic logic [31:0] crc32_step(logic [31:0] c, logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'h0, d};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/ftx_crc32.sv
module ftx_crc32
    import ftx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] crc_out
);
    logic [31:0] acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '1;
        end else if (clear) begin
            acc <= en ? crc32_step('1, din) : '1;
        end else if (en) begin
            acc <= crc32_step(acc, din);
        end
    end

    assign crc_out = ~acc;
endmodule

// File: rtl/ftx_frame_buf.sv
module ftx_frame_buf #(
    parameter int DEPTH = 2059,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

    // R1
    buf_waddr_range_chk: assert property (@(posedge clk) disable iff (rst)
        we |-> (int'(waddr) < DEPTH));
endmodule

// File: rtl/ftx_framer.sv
module ftx_framer
    import ftx_pkg::*;
#(
    parameter int MAX_PAYLOAD = 2048
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_last,
    output logic        in_ready,
    input  logic [15:0] hdr_dst,
    input  logic [15:0] hdr_src,
    input  logic [7:0]  hdr_type,
    input  logic        resend_req,
    input  logic        bus_grant,
    output logic        bus_req,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_sof,
    output logic        tx_eof,
    output logic        frame_done,
    output logic        ovf_err
);
    localparam int DEPTH = HDR_BYTES + MAX_PAYLOAD + CRC_BYTES;
    localparam int AW = $clog2(DEPTH);

    ftx_state_e    state;
    ftx_hdr_t      hdr;
    logic [AW-1:0] pay_len;
    logic [3:0]    seal_k;
    logic [AW-1:0] rd_ptr;
    logic          ovf_q;

    logic          accept;
    logic          at_limit;
    logic [AW-1:0] last_idx;
    logic [55:0]   hdr_vec;
    logic [31:0]   crc_val;

    logic          buf_we;
    logic [AW-1:0] buf_waddr;
    logic [7:0]    buf_wdata;
    logic          crc_clr;
    logic          crc_en;

    assign in_ready = (state == ST_IDLE && !resend_req) || state == ST_FILL || state == ST_DROP;
    assign accept   = in_valid && in_ready;
    assign at_limit = (pay_len == AW'(MAX_PAYLOAD));
    assign last_idx = AW'(SEAL_STEPS - 1) + pay_len;
    assign hdr_vec  = {hdr, 16'(pay_len)};

    always_comb begin
        buf_we    = 1'b0;
        buf_waddr = '0;
        buf_wdata = '0;
        crc_clr   = 1'b0;
        crc_en    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                crc_clr   = 1'b1;
                crc_en    = accept;
                buf_we    = accept;
                buf_waddr = AW'(HDR_BYTES);
                buf_wdata = in_data;
            end
            ST_FILL: begin
                crc_en    = accept && !at_limit;
                buf_we    = accept && !at_limit;
                buf_waddr = AW'(HDR_BYTES) + pay_len;
                buf_wdata = in_data;
            end
            ST_SEAL: begin
                buf_we = 1'b1;
                if (seal_k < 4'(HDR_BYTES)) begin
                    buf_waddr = AW'(seal_k);
                    buf_wdata = hdr_vec[8*(HDR_BYTES-1-int'(seal_k)) +: 8];
                end else begin
                    buf_waddr = AW'(HDR_BYTES) + pay_len + AW'(seal_k - 4'(HDR_BYTES));
                    buf_wdata = crc_val[8*(SEAL_STEPS-1-int'(seal_k)) +: 8];
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            hdr     <= '0;
            pay_len <= '0;
            seal_k  <= '0;
            rd_ptr  <= '0;
            ovf_q   <= 1'b0;
        end else begin
            ovf_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    seal_k <= '0;
                    if (resend_req) begin
                        hdr     <= '{dst: hdr_dst, src: hdr_src, ftype: RESEND_TYPE};
                        pay_len <= '0;
                        state   <= ST_SEAL;
                    end else if (accept) begin
                        hdr     <= '{dst: hdr_dst, src: hdr_src, ftype: hdr_type};
                        pay_len <= AW'(1);
                        state   <= in_last ? ST_SEAL : ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (accept) begin
                        if (at_limit) begin
                            ovf_q <= 1'b1;
                            state <= in_last ? ST_IDLE : ST_DROP;
                        end else begin
                            pay_len <= pay_len + AW'(1);
                            if (in_last) state <= ST_SEAL;
                        end
                    end
                end
                ST_DROP: begin
                    if (accept && in_last) state <= ST_IDLE;
                end
                ST_SEAL: begin
                    seal_k <= seal_k + 4'd1;
                    if (seal_k == 4'(SEAL_STEPS - 1)) state <= ST_WAIT;
                end
                ST_WAIT: begin
                    rd_ptr <= '0;
                    if (bus_grant) state <= ST_SEND;
                end
                ST_SEND: begin
                    rd_ptr <= rd_ptr + AW'(1);
                    if (rd_ptr == last_idx) state <= ST_DONE;
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    ftx_crc32 u_crc (
        .clk     (clk),
        .rst     (rst),
        .clear   (crc_clr),
        .en      (crc_en),
        .din     (in_data),
        .crc_out (crc_val)
    );

    ftx_frame_buf #(.DEPTH(DEPTH)) u_buf (
        .clk   (clk),
        .rst   (rst),
        .we    (buf_we),
        .waddr (buf_waddr),
        .wdata (buf_wdata),
        .raddr (rd_ptr),
        .rdata (tx_data)
    );

    assign bus_req    = (state == ST_WAIT) || (state == ST_SEND);
    assign tx_valid   = (state == ST_SEND);
    assign tx_sof     = tx_valid && (rd_ptr == '0);
    assign tx_eof     = tx_valid && (rd_ptr == last_idx);
    assign frame_done = (state == ST_DONE);
    assign ovf_err    = ovf_q;

    // R4
    req_after_seal_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |-> $past(state == ST_SEAL));
    // R5
    tx_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> bus_req);
    // R5
    start_after_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_valid) |-> $past(bus_grant));
    // R5
    stream_gapless_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_eof) |=> tx_valid);
    // R6
    sof_marks_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_valid) |-> tx_sof);
    // R7
    done_follows_eof_chk: assert property (@(posedge clk) disable iff (rst)
        tx_eof |=> (frame_done && !bus_req));
    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);
    // R8
    no_intake_while_req_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> !in_ready);
    // R9
    ovf_no_req_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_err |-> !bus_req);
endmodule

// File: tb/ftx_framer_test.sv
module ftx_framer_test;
    localparam int MAXP = 2048;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic [15:0] hdr_dst = '0;
    logic [15:0] hdr_src = '0;
    logic [7:0]  hdr_type = '0;
    logic        resend_req = 1'b0;
    logic        bus_grant = 1'b0;
    logic        bus_req, tx_valid, tx_sof, tx_eof, frame_done, ovf_err;
    logic [7:0]  tx_data;

    int checks = 0;
    int fails = 0;
    logic [7:0] pay [0:2100];
    logic [7:0] rx  [0:2100];
    int rx_n;
    bit ovf_seen;
    bit req_seen;

    always #5 clk = ~clk;

    ftx_framer #(.MAX_PAYLOAD(MAXP)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_ready(in_ready), .hdr_dst(hdr_dst), .hdr_src(hdr_src), .hdr_type(hdr_type),
        .resend_req(resend_req), .bus_grant(bus_grant), .bus_req(bus_req),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_sof(tx_sof), .tx_eof(tx_eof),
        .frame_done(frame_done), .ovf_err(ovf_err)
    );

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(int n);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < n; i++) begin
            for (int b = 0; b < 8; b++) begin
                logic fb = pay[i][b] ^ c[0];
                c = c >> 1;
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        return ~c;
    endfunction

    // drive n payload bytes from pay[]; R4: no request during intake
    task automatic feed(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            in_valid = 1'b1;
            in_data  = pay[i];
            in_last  = (i == n - 1);
            if (bus_req) chk(1'b0, "R4", "req during intake", 1, 0);
            if (ovf_err) ovf_seen = 1'b1;
        end
        @(negedge clk);
        if (ovf_err) ovf_seen = 1'b1;
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic collect(int gdelay);
        int guard = 0;
        rx_n = 0;
        while (!bus_req && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        chk(bus_req, "R4", "request raised after seal", bus_req, 1);
        chk(!in_ready, "R8", "in_ready low while requesting", in_ready, 0);
        for (int i = 0; i < gdelay; i++) begin
            chk(!tx_valid && bus_req, "R5", "idle without grant", tx_valid, 0);
            @(negedge clk);
        end
        bus_grant = 1'b1;
        forever begin
            @(negedge clk);
            if (!tx_valid) begin
                chk(1'b0, "R5", "gap in stream", 0, 1);
                break;
            end
            rx[rx_n] = tx_data;
            if (tx_sof != (rx_n == 0)) chk(1'b0, "R6", "sof placement", tx_sof, rx_n == 0);
            rx_n++;
            if (tx_eof || rx_n > 2090) break;
        end
        @(negedge clk);
        bus_grant = 1'b0;
        chk(frame_done && !bus_req, "R7", "done pulse and req drop", {frame_done, bus_req}, 2'b10);
        @(negedge clk);
        chk(!frame_done && in_ready, "R7", "done is single cycle", frame_done, 0);
    endtask

    task automatic check_frame(logic [15:0] d, logic [15:0] s, logic [7:0] t, int n, string req);
        logic [31:0] c = ref_crc(n);
        bit ok = 1'b1;
        chk(rx_n == 11 + n, "R1", "frame size", rx_n, 11 + n);
        chk({rx[0], rx[1]} == d, "R1", "destination", {rx[0], rx[1]}, d);
        chk({rx[2], rx[3]} == s, "R1", "source", {rx[2], rx[3]}, s);
        chk(rx[4] == t, req, "type", rx[4], t);
        chk({rx[5], rx[6]} == 16'(n), "R2", "length", {rx[5], rx[6]}, n);
        for (int i = 0; i < n; i++) if (rx[7 + i] != pay[i]) ok = 1'b0;
        chk(ok, "R1", "data bytes", ok, 1);
        chk({rx[7+n], rx[8+n], rx[9+n], rx[10+n]} == c, "R3", "crc field",
            {rx[7+n], rx[8+n], rx[9+n], rx[10+n]}, c);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({bus_req, tx_valid, tx_sof, tx_eof, frame_done, ovf_err} == 0, "R11",
            "outputs after reset", {bus_req, tx_valid, tx_sof, tx_eof, frame_done, ovf_err}, 0);
        chk(in_ready, "R11", "ready after reset", in_ready, 1);
    endtask

    task automatic t_known_crc();
        string s = "123456789";
        for (int i = 0; i < 9; i++) pay[i] = s[i];
        hdr_dst = 16'h1234; hdr_src = 16'hABCD; hdr_type = 8'h01;
        feed(9);
        chk(!bus_req, "R4", "no request while sealing", bus_req, 0);
        hdr_dst = 16'h0; hdr_src = 16'h0; hdr_type = 8'h0;
        collect(3);
        check_frame(16'h1234, 16'hABCD, 8'h01, 9, "R1");
        chk({rx[16], rx[17], rx[18], rx[19]} == 32'hCBF43926, "R3", "check string crc",
            {rx[16], rx[17], rx[18], rx[19]}, 32'hCBF43926);
    endtask

    task automatic t_single_byte();
        pay[0] = 8'h5A;
        hdr_dst = 16'hFF00; hdr_src = 16'h00FF; hdr_type = 8'h02;
        feed(1);
        collect(0);
        check_frame(16'hFF00, 16'h00FF, 8'h02, 1, "R2");
    endtask

    task automatic t_intake_blocked();
        for (int i = 0; i < 20; i++) pay[i] = 8'(i * 7 + 3);
        hdr_dst = 16'h0102; hdr_src = 16'h0304; hdr_type = 8'h05;
        feed(20);
        while (!bus_req) @(negedge clk);
        in_valid = 1'b1; in_data = 8'hEE; in_last = 1'b1;
        @(negedge clk);
        chk(!in_ready, "R8", "payload refused while waiting", in_ready, 0);
        in_valid = 1'b0; in_last = 1'b0;
        collect(5);
        check_frame(16'h0102, 16'h0304, 8'h05, 20, "R8");
    endtask

    task automatic t_full_length();
        for (int i = 0; i < MAXP; i++) pay[i] = 8'(i ^ (i >> 8));
        hdr_dst = 16'h7777; hdr_src = 16'h8888; hdr_type = 8'h09;
        feed(MAXP);
        chk(!ovf_seen, "R2", "no overflow at limit", ovf_seen, 0);
        collect(1);
        check_frame(16'h7777, 16'h8888, 8'h09, MAXP, "R2");
    endtask

    task automatic t_overflow(int n);
        for (int i = 0; i < n; i++) pay[i] = 8'(i + 1);
        ovf_seen = 1'b0;
        req_seen = 1'b0;
        feed(n);
        for (int i = 0; i < 30; i++) begin
            if (bus_req) req_seen = 1'b1;
            if (ovf_err) ovf_seen = 1'b1;
            @(negedge clk);
        end
        chk(ovf_seen, "R9", "overflow pulse", ovf_seen, 1);
        chk(!req_seen, "R9", "no request for dropped payload", req_seen, 0);
        chk(in_ready, "R9", "back to idle", in_ready, 1);
        ovf_seen = 1'b0;
        for (int i = 0; i < 4; i++) pay[i] = 8'hC0 + 8'(i);
        hdr_dst = 16'h4242; hdr_src = 16'h2424; hdr_type = 8'h03;
        feed(4);
        collect(2);
        check_frame(16'h4242, 16'h2424, 8'h03, 4, "R9");
    endtask

    task automatic t_resend();
        hdr_dst = 16'hBEEF; hdr_src = 16'hCAFE; hdr_type = 8'h11;
        @(negedge clk);
        resend_req = 1'b1;
        @(negedge clk);
        resend_req = 1'b0;
        collect(2);
        check_frame(16'hBEEF, 16'hCAFE, 8'hE0, 0, "R10");
        chk({rx[7], rx[8], rx[9], rx[10]} == 32'h0, "R10", "empty crc",
            {rx[7], rx[8], rx[9], rx[10]}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        ovf_seen = 1'b0;
        t_reset();
        t_known_crc();
        t_single_byte();
        t_intake_blocked();
        t_full_length();
        t_overflow(MAXP + 2);
        t_overflow(MAXP + 1);
        t_resend();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule